// File: doc/BRIEF.md
# Chip-Failure-Tolerant Line ECC Codec

This block protects a 256-bit memory line stored across 72 four-bit-wide DRAM devices, a 288-bit image in total. The line is split into four 64-bit words, and each word gets its own 8 check bits from a single-error-correcting, double-error-detecting code. The bits of the four code words are interleaved so that the four data pins of every device each carry a bit of a different code word. If one device fails outright, each code word sees at most one wrong bit, and each word corrects that bit on its own.

On the write side the block merges a byte-strobed update into a full base line. Any update smaller than the full 32 bytes therefore becomes a read-modify-write: the caller reads the line, passes the corrected old data as the base, and writes the merged result back. The block then emits the 288-bit stored image. On the read side it takes a 288-bit image and returns the corrected data. It also returns a correction flag and an uncorrectable flag for each word, a line-level uncorrectable flag, and a device-failure indication with the device number. Both paths have one register stage.

Top module: `chipkill_codec`

## Requirements
- R1: Word w holds data bits wr_data[64w+63:64w] at code positions 0..63 and check bits 0..7 at positions 64..71. The column for check bit i has only bit i set. The column for data position k is the k-th smallest (counting from 0) 8-bit value with odd weight of at least 3. Each check bit is the XOR of the data bits whose column has that bit set. Code position p of word w is stored at line bit 4p+w, so device c holds bits 4c..4c+3.
- R2: An image written by R1 reads back with the original data and with every status flag clear.
- R3: One flipped bit in a word, whether a data or a check position, sets that word's correction flag and returns correct data.
- R4: When all four bits of one device are inverted, all four correction flags are set, the data is correct, and chip_fail is raised with chip_idx equal to the device number (0..71).
- R5: A word whose syndrome is non-zero and matches no column sets its uncorrectable flag. Its 64 data bits are delivered unmodified. line_uncorr is set when any word is uncorrectable.
- R6: A word never reports correction and uncorrectable together. Each word is classified independently of the other words.
- R7: chip_fail is raised only when all four words are corrected at the same code position. When it is low, chip_idx reads 0.
- R8: Byte b of the encoded data (bits 8b+7:8b) comes from wr_data when wr_strb[b] is 1 and from wr_base when it is 0.
- R9: enc_valid and dec_valid follow wr_valid and rd_valid one cycle later. Back-to-back requests give back-to-back results. While dec_valid is low, all read status outputs are 0.
- R10: In reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Encode request |
| wr_data | input | 256 | New line data |
| wr_strb | input | 32 | Byte select: 1 takes wr_data, 0 takes wr_base |
| wr_base | input | 256 | Old line data for a partial update |
| enc_valid | output | 1 | Stored image valid |
| enc_line | output | 288 | Interleaved stored image |
| rd_valid | input | 1 | Decode request |
| rd_line | input | 288 | Image read from memory |
| dec_valid | output | 1 | Decode result valid |
| dec_data | output | 256 | Corrected line data |
| dec_corr | output | 4 | Per-word single-bit correction flag |
| dec_uncorr | output | 4 | Per-word uncorrectable flag |
| line_uncorr | output | 1 | Any word uncorrectable |
| chip_fail | output | 1 | All four words corrected on one device |
| chip_idx | output | 7 | Failed device number |

## Verification
The hardest case is the whole-device failure. To reach it from the ports, the bench must build an image in which exactly the four bits of one device are inverted. It must then tell that case apart from images where all four words are corrected at different positions, or on only part of a device. The bench encodes lines with its own model of the code and XORs device-shaped masks onto them. It uses a data-only device, a check-bit device and device 0. It also uses near misses: three words at one position and the fourth at the next, and two bits of one device. Pairs of adjacent devices produce double errors in every word at once.

// File: rtl/chipkill_codec.sv
module chipkill_codec #(
  parameter int WORDS = 4,
  parameter int DBITS = 64,
  parameter int CBITS = 8
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    wr_valid,
  input  logic [WORDS*DBITS-1:0]                  wr_data,
  input  logic [WORDS*DBITS/8-1:0]                wr_strb,
  input  logic [WORDS*DBITS-1:0]                  wr_base,
  output logic                                    enc_valid,
  output logic [WORDS*(DBITS+CBITS)-1:0]          enc_line,
  input  logic                                    rd_valid,
  input  logic [WORDS*(DBITS+CBITS)-1:0]          rd_line,
  output logic                                    dec_valid,
  output logic [WORDS*DBITS-1:0]                  dec_data,
  output logic [WORDS-1:0]                        dec_corr,
  output logic [WORDS-1:0]                        dec_uncorr,
  output logic                                    line_uncorr,
  output logic                                    chip_fail,
  output logic [$clog2(DBITS+CBITS)-1:0]          chip_idx
);
  localparam int NB = DBITS + CBITS;
  localparam int LD = WORDS * DBITS;
  localparam int LS = WORDS * NB;
  localparam int PW = $clog2(NB);

  function automatic logic [NB*CBITS-1:0] build_cols();
    logic [NB*CBITS-1:0] t;
    int n;
    t = '0;
    n = 0;
    for (int v = 1; v < (1 << CBITS); v++) begin
      if (n < DBITS && ($countones(v[CBITS-1:0]) % 2 == 1) && $countones(v[CBITS-1:0]) >= 3) begin
        t[n*CBITS +: CBITS] = v[CBITS-1:0];
        n++;
      end
    end
    for (int i = 0; i < CBITS; i++) t[(DBITS+i)*CBITS + i] = 1'b1;
    return t;
  endfunction

  localparam logic [NB*CBITS-1:0] COLS = build_cols();

  logic [LD-1:0]    merged;
  logic [LS-1:0]    enc_n;
  logic [LD-1:0]    data_n;
  logic [WORDS-1:0] corr_n, unc_n;
  logic [PW-1:0]    pos_n [WORDS];
  logic             same_pos, chip_n;

  for (genvar b = 0; b < LD/8; b++) begin : g_merge
    assign merged[8*b +: 8] = wr_strb[b] ? wr_data[8*b +: 8] : wr_base[8*b +: 8];
  end

  always_comb begin : p_enc
    logic [CBITS-1:0] chk;
    enc_n = '0;
    for (int w = 0; w < WORDS; w++) begin
      chk = '0;
      for (int k = 0; k < DBITS; k++) begin
        if (merged[w*DBITS+k]) chk = chk ^ COLS[k*CBITS +: CBITS];
        enc_n[k*WORDS+w] = merged[w*DBITS+k];
      end
      for (int i = 0; i < CBITS; i++) enc_n[(DBITS+i)*WORDS+w] = chk[i];
    end
  end

  always_comb begin : p_dec
    logic [NB-1:0]    cw;
    logic [CBITS-1:0] syn;
    logic             hit;
    data_n = '0;
    corr_n = '0;
    unc_n  = '0;
    for (int w = 0; w < WORDS; w++) begin
      syn = '0;
      hit = 1'b0;
      pos_n[w] = '0;
      for (int p = 0; p < NB; p++) begin
        cw[p] = rd_line[p*WORDS+w];
        if (cw[p]) syn = syn ^ COLS[p*CBITS +: CBITS];
      end
      for (int p = 0; p < NB; p++) begin
        if (syn == COLS[p*CBITS +: CBITS]) begin
          hit = 1'b1;
          pos_n[w] = PW'(p);
          cw[p] = ~cw[p];
        end
      end
      corr_n[w] = (syn != '0) && hit;
      unc_n[w]  = (syn != '0) && !hit;
      data_n[w*DBITS +: DBITS] = cw[DBITS-1:0];
    end
  end

  always_comb begin
    same_pos = 1'b1;
    for (int w = 1; w < WORDS; w++) same_pos = same_pos && (pos_n[w] == pos_n[0]);
  end

  assign chip_n = (&corr_n) && same_pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enc_valid   <= 1'b0;
      enc_line    <= '0;
      dec_valid   <= 1'b0;
      dec_data    <= '0;
      dec_corr    <= '0;
      dec_uncorr  <= '0;
      line_uncorr <= 1'b0;
      chip_fail   <= 1'b0;
      chip_idx    <= '0;
    end else begin
      enc_valid   <= wr_valid;
      if (wr_valid) enc_line <= enc_n;
      dec_valid   <= rd_valid;
      if (rd_valid) dec_data <= data_n;
      dec_corr    <= rd_valid ? corr_n : '0;
      dec_uncorr  <= rd_valid ? unc_n : '0;
      line_uncorr <= rd_valid && (|unc_n);
      chip_fail   <= rd_valid && chip_n;
      chip_idx    <= (rd_valid && chip_n) ? pos_n[0] : '0;
    end
  end
endmodule

module chipkill_codec_chk #(
  parameter int WORDS = 4,
  parameter int PW = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             rd_valid,
  input logic             enc_valid,
  input logic             dec_valid,
  input logic [WORDS-1:0] dec_corr,
  input logic [WORDS-1:0] dec_uncorr,
  input logic             line_uncorr,
  input logic             chip_fail,
  input logic [PW-1:0]    chip_idx
);
  p_enc_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (enc_valid == $past(wr_valid)));
  p_dec_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (dec_valid == $past(rd_valid)));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (dec_corr == '0 && dec_uncorr == '0 && !line_uncorr && !chip_fail));
  p_excl_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_corr & dec_uncorr) == '0);
  p_chip_all_corr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chip_fail |-> ((&dec_corr) && !line_uncorr));
  p_line_any_r5: assert property (@(posedge clk) disable iff (!rst_n)
    line_uncorr == (|dec_uncorr));
  p_idx_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_fail |-> (chip_idx == '0));
endmodule

bind chipkill_codec chipkill_codec_chk #(.WORDS(WORDS), .PW($clog2(DBITS+CBITS))) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_valid(rd_valid),
  .enc_valid(enc_valid), .dec_valid(dec_valid), .dec_corr(dec_corr),
  .dec_uncorr(dec_uncorr), .line_uncorr(line_uncorr), .chip_fail(chip_fail),
  .chip_idx(chip_idx)
);

// File: tb/tb_chipkill_codec.sv
module tb_chipkill_codec;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic [255:0] wr_data = '0;
  logic [31:0]  wr_strb = '0;
  logic [255:0] wr_base = '0;
  logic         enc_valid;
  logic [287:0] enc_line;
  logic         rd_valid = 1'b0;
  logic [287:0] rd_line = '0;
  logic         dec_valid;
  logic [255:0] dec_data;
  logic [3:0]   dec_corr, dec_uncorr;
  logic         line_uncorr, chip_fail;
  logic [6:0]   chip_idx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0]   cols [72];
  logic [287:0] enc_q [$];
  string        enc_tag [$];
  logic [272:0] dec_q [$];
  string        dec_tag [$];

  chipkill_codec dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_strb(wr_strb), .wr_base(wr_base), .enc_valid(enc_valid), .enc_line(enc_line),
    .rd_valid(rd_valid), .rd_line(rd_line), .dec_valid(dec_valid), .dec_data(dec_data),
    .dec_corr(dec_corr), .dec_uncorr(dec_uncorr), .line_uncorr(line_uncorr),
    .chip_fail(chip_fail), .chip_idx(chip_idx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [287:0] tb_enc(input logic [255:0] d);
    logic [287:0] r;
    logic [7:0]   c;
    r = '0;
    for (int w = 0; w < 4; w++) begin
      c = '0;
      for (int k = 0; k < 64; k++) begin
        if (d[64*w+k]) c = c ^ cols[k];
        r[4*k+w] = d[64*w+k];
      end
      for (int i = 0; i < 8; i++) r[4*(64+i)+w] = c[i];
    end
    return r;
  endfunction

  function automatic logic [255:0] tb_merge(input logic [255:0] d, input logic [31:0] s,
                                            input logic [255:0] b);
    logic [255:0] r;
    for (int k = 0; k < 32; k++) r[8*k +: 8] = s[k] ? d[8*k +: 8] : b[8*k +: 8];
    return r;
  endfunction

  function automatic logic [255:0] pat(input int unsigned seed);
    logic [255:0] r;
    int unsigned  x;
    x = seed * 32'd2654435761 + 32'd1;
    for (int k = 0; k < 8; k++) begin
      x = x * 32'd1664525 + 32'd1013904223;
      r[32*k +: 32] = x;
    end
    return r;
  endfunction

  function automatic logic [287:0] fl(input int n);
    return 288'(1) << n;
  endfunction

  function automatic logic [255:0] fd(input int n);
    return 256'(1) << n;
  endfunction

  task automatic check(input bit ok, input string req, input logic [287:0] act,
                       input logic [287:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [255:0] d, input logic [31:0] s, input logic [255:0] b,
                       input string tag);
    @(negedge clk);
    wr_data = d; wr_strb = s; wr_base = b; wr_valid = 1'b1;
    enc_q.push_back(tb_enc(tb_merge(d, s, b)));
    enc_tag.push_back(tag);
  endtask

  task automatic do_rd(input logic [287:0] line, input logic [255:0] d, input logic [3:0] c,
                       input logic [3:0] u, input logic f, input logic [6:0] i, input string tag);
    @(negedge clk);
    rd_line = line; rd_valid = 1'b1;
    dec_q.push_back({d, c, u, |u, f, i});
    dec_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    logic [287:0] ee;
    logic [272:0] de;
    string        t;
    if (rst_n && enc_valid) begin
      if (enc_q.size() == 0) check(1'b0, "R9 unexpected enc_valid", 288'(1), 288'(0));
      else begin
        ee = enc_q.pop_front();
        t = enc_tag.pop_front();
        check(enc_line === ee, t, enc_line, ee);
      end
    end
    if (rst_n && dec_valid) begin
      if (dec_q.size() == 0) check(1'b0, "R9 unexpected dec_valid", 288'(1), 288'(0));
      else begin
        de = dec_q.pop_front();
        t = dec_tag.pop_front();
        check(dec_data === de[272:17], {t, " data"}, 288'(dec_data), 288'(de[272:17]));
        check({dec_corr, dec_uncorr, line_uncorr, chip_fail, chip_idx} === de[16:0],
              {t, " status"}, 288'({dec_corr, dec_uncorr, line_uncorr, chip_fail, chip_idx}),
              288'(de[16:0]));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [255:0] p0, p1, p2, p3;
    logic [287:0] g2, g3;
    begin
      int n;
      n = 0;
      for (int v = 1; v < 256; v++)
        if (n < 64 && ($countones(v[7:0]) % 2 == 1) && $countones(v[7:0]) >= 3) begin
          cols[n] = v[7:0];
          n++;
        end
      for (int i = 0; i < 8; i++) cols[64+i] = 8'(1) << i;
    end
    p0 = '0; p1 = '1; p2 = pat(1); p3 = pat(2);
    g2 = tb_enc(p2); g3 = tb_enc(p3);

    repeat (3) @(negedge clk);
    check(!enc_valid && !dec_valid, "R10 reset valids", 288'({enc_valid, dec_valid}), 288'(0));
    check(enc_line === '0, "R10 reset enc_line", enc_line, 288'(0));
    check(dec_data === '0, "R10 reset dec_data", 288'(dec_data), 288'(0));
    check({dec_corr, dec_uncorr, line_uncorr, chip_fail, chip_idx} === '0, "R10 reset status",
          288'({dec_corr, dec_uncorr, line_uncorr, chip_fail, chip_idx}), 288'(0));
    @(negedge clk); rst_n = 1'b1;

    do_wr(p0, '1, '0, "R1 encode zeros");
    do_wr(p1, '1, '0, "R1 encode ones");
    do_wr(p2, '1, '0, "R1 encode pattern a");
    do_wr(p3, '1, p1, "R1 encode pattern b");
    do_wr(p2, 32'h0000_FFFF, p3, "R8 merge low half");
    do_wr(p2, 32'hA5A5_0F0F, p1, "R8 merge mixed bytes");
    do_wr(p2, 32'h0, p3, "R8 no strobe keeps base");
    @(negedge clk); wr_valid = 1'b0;

    do_rd(tb_enc(p0), p0, 4'h0, 4'h0, 1'b0, 7'd0, "R2 clean zeros");
    do_rd(tb_enc(p1), p1, 4'h0, 4'h0, 1'b0, 7'd0, "R2 clean ones");
    do_rd(g2, p2, 4'h0, 4'h0, 1'b0, 7'd0, "R2 clean pattern");
    do_rd(g2 ^ fl(20), p2, 4'h1, 4'h0, 1'b0, 7'd0, "R3 word0 data bit");
    do_rd(g2 ^ fl(266), p2, 4'h4, 4'h0, 1'b0, 7'd0, "R3 word2 check bit");
    do_rd(g3 ^ fl(255), p3, 4'h8, 4'h0, 1'b0, 7'd0, "R3 word3 top data bit");
    do_rd(g2 ^ (288'hF << 36), p2, 4'hF, 4'h0, 1'b1, 7'd9, "R4 device 9 dead");
    do_rd(g3 ^ (288'hF << 280), p3, 4'hF, 4'h0, 1'b1, 7'd70, "R4 check device 70 dead");
    do_rd(g2 ^ 288'hF, p2, 4'hF, 4'h0, 1'b1, 7'd0, "R4 device 0 dead");
    do_rd(g2 ^ fl(0) ^ fl(2), p2, 4'h5, 4'h0, 1'b0, 7'd0, "R7 half device");
    do_rd(g2 ^ fl(12) ^ fl(29) ^ fl(46) ^ fl(83), p2, 4'hF, 4'h0, 1'b0, 7'd0,
          "R7 four positions differ");
    do_rd(g2 ^ fl(20) ^ fl(21) ^ fl(22) ^ fl(27), p2, 4'hF, 4'h0, 1'b0, 7'd0,
          "R7 three match one off");
    do_rd(g2 ^ fl(9) ^ fl(37), p2 ^ fd(66) ^ fd(73), 4'h0, 4'h2, 1'b0, 7'd0,
          "R5 double in word1");
    do_rd(g2 ^ fl(9) ^ fl(37) ^ fl(123), p2 ^ fd(66) ^ fd(73), 4'h8, 4'h2, 1'b0, 7'd0,
          "R6 double word1 single word3");
    do_rd(g2 ^ (288'hFF << 36),
          p2 ^ fd(9) ^ fd(10) ^ fd(73) ^ fd(74) ^ fd(137) ^ fd(138) ^ fd(201) ^ fd(202),
          4'h0, 4'hF, 1'b0, 7'd0, "R5 two devices dead");
    @(negedge clk); rd_valid = 1'b0; rd_line = g2 ^ (288'hF << 36);
    @(negedge clk);
    check(!dec_valid && dec_corr == 4'h0 && !chip_fail, "R9 idle cycle quiet",
          288'({dec_valid, dec_corr, chip_fail}), 288'(0));
    repeat (3) @(negedge clk);
    check(enc_q.size() == 0 && dec_q.size() == 0, "R9 every request answered",
          288'(enc_q.size() + dec_q.size()), 288'(0));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule